// File: doc/BRIEF.md
# Page Write Load Controller

This block controls writes into a byte-wide non-volatile memory. Host write strobes, already sampled into the clock domain, are gathered into a page buffer with one valid flag per byte. The first accepted strobe locks the page number. Each further strobe must arrive within a configurable gap. When the gap passes with no new strobe, loading stops and the block enters a timed programming phase. During that phase it holds `busy` high, and reads return a status word in place of array data. When the phase ends, only the flagged bytes are written into the array model, and the flags are cleared.

The array is a simple model of the cell matrix. It covers `MODEL_PAGES` pages, selected by the low bits of the page number, and every byte starts at 0xFF after reset. All timing is counted in clock cycles: the minimum strobe width, the allowed gap between bytes and the programming time.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset `busy` is 0, every array byte reads as 0xFF, and `dout` is 0 whenever no read access is active.
- R2: A write strobe is the interval in which `ce_n` and `we_n` are both 0. The strobe is accepted only if `oe_n` stays 1 for the whole strobe and in the cycle where it ends. Strobes with `oe_n` low are ignored, and `we_n` low while `ce_n` is high is not a strobe.
- R3: A strobe active for fewer than `MIN_PW` consecutive sampled cycles is ignored. A strobe of exactly `MIN_PW` cycles is accepted.
- R4: The address is taken in the first cycle of the strobe. The data is taken in the first cycle after the strobe ends. Address changes later in the strobe have no effect.
- R5: Address bits [12:6] of the first accepted strobe lock the page for the load period. A strobe that names a different page is ignored. Bits [5:0] give the byte offset within the page.
- R6: Bytes may be loaded in any order. A second load of the same offset within one load period replaces the first value.
- R7: Programming writes only the loaded offsets. All other bytes of the page keep their previous contents.
- R8: `busy` rises `GAP_CYC` clock edges after the edge at which the last strobe was accepted. The gap count is paused while a strobe is active, so a long strobe does not end loading.
- R9: `busy` stays high for exactly `PROG_CYC` cycles. The loaded bytes appear in the array when `busy` falls, and the valid flags are cleared at that point, so a later load never rewrites bytes from an earlier one.
- R10: A read while `busy` is high returns status. Bit 7 is the inverse of bit 7 of the last accepted data byte. Bit 6 flips at the start of each new read access. Bits 5:0 are 0.
- R11: Strobes that begin or end while `busy` is high are ignored, and they do not start a new load.
- R12: A read access (`ce_n`=0, `oe_n`=0, `we_n`=1) while idle returns the array byte at the page and offset given by `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the high bits, offset in the low `OFF_W` bits |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or status word; 0 when no read is active |
| busy | output | 1 | High during the programming phase |

## Verification
The bench builds the block with `MIN_PW`=3, `GAP_CYC`=20, `PROG_CYC`=30 and `MODEL_PAGES`=4. These short counts let every load period, timeout and programming phase run to completion many times within the run. They also allow an exact cycle count for when `busy` rises and how long it stays high. With four model pages, a stale valid flag would show up as a byte written into another page. A strobe just one cycle under the minimum width separates the glitch filter from a normal write.

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 6,
  parameter int MIN_PW      = 2,
  parameter int GAP_CYC     = 19200,
  parameter int PROG_CYC    = 250000,
  parameter int MODEL_PAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PG_W       = ADDR_W - OFF_W;
  localparam int PIDX_W     = (MODEL_PAGES > 1) ? $clog2(MODEL_PAGES) : 1;
  localparam int MEM_D      = (1 << PIDX_W) * PAGE_BYTES;
  localparam int MIDX_W     = PIDX_W + OFF_W;
  localparam int PW_W       = $clog2(MIN_PW + 1);
  localparam int GAP_W      = $clog2(GAP_CYC + 1);
  localparam int PROG_W     = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;
  st_t state;

  logic                  strb, strb_q, strb_end, rd_act, rd_q;
  logic [ADDR_W-1:0]     cap_addr;
  logic [PW_W-1:0]       pw_cnt;
  logic                  pulse_ok, pg_hit, accept;
  logic [PG_W-1:0]       lock_pg;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     pbuf [PAGE_BYTES];
  logic [DATA_W-1:0]     mem  [MEM_D];
  logic [DATA_W-1:0]     last_d;
  logic                  tog;
  logic [GAP_W-1:0]      gap_cnt;
  logic [PROG_W-1:0]     prog_cnt;

  assign strb     = ~ce_n & ~we_n;
  assign strb_end = strb_q & ~strb;
  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign busy     = (state == S_PROG);
  assign pg_hit   = (state == S_IDLE) || (cap_addr[ADDR_W-1:OFF_W] == lock_pg);
  assign accept   = strb_end && pulse_ok && oe_n && (pw_cnt == PW_W'(MIN_PW))
                    && (state != S_PROG) && pg_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      rd_q     <= 1'b0;
      cap_addr <= '0;
      pw_cnt   <= '0;
      pulse_ok <= 1'b0;
    end else begin
      strb_q <= strb;
      rd_q   <= rd_act;
      if (strb && !strb_q) begin
        cap_addr <= addr;
        pw_cnt   <= PW_W'(1);
        pulse_ok <= oe_n & ~busy;
      end else if (strb) begin
        if (pw_cnt != PW_W'(MIN_PW)) pw_cnt <= pw_cnt + PW_W'(1);
        pulse_ok <= pulse_ok & oe_n & ~busy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else if (rd_act && !rd_q && busy) tog <= ~tog;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (accept) begin
      pbuf[cap_addr[OFF_W-1:0]] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mask     <= '0;
      lock_pg  <= '0;
      last_d   <= '0;
      gap_cnt  <= '0;
      prog_cnt <= '0;
      for (int i = 0; i < MEM_D; i++) mem[i] <= '1;
    end else begin
      if (accept) begin
        mask[cap_addr[OFF_W-1:0]] <= 1'b1;
        last_d  <= din;
        gap_cnt <= '0;
        if (state == S_IDLE) begin
          lock_pg <= cap_addr[ADDR_W-1:OFF_W];
          state   <= S_LOAD;
        end
      end else begin
        case (state)
          S_LOAD: begin
            if (!strb) begin
              if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                state    <= S_PROG;
                prog_cnt <= '0;
              end else begin
                gap_cnt <= gap_cnt + GAP_W'(1);
              end
            end
          end
          S_PROG: begin
            if (prog_cnt == PROG_W'(PROG_CYC - 1)) begin
              for (int i = 0; i < PAGE_BYTES; i++)
                if (mask[i]) mem[{lock_pg[PIDX_W-1:0], OFF_W'(i)}] <= pbuf[i];
              mask  <= '0;
              state <= S_IDLE;
            end else begin
              prog_cnt <= prog_cnt + PROG_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout = !rd_act ? '0 :
                busy    ? {~last_d[DATA_W-1], tog, {(DATA_W-2){1'b0}}} :
                          mem[addr[MIDX_W-1:0]];

  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask));
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mask == '0));
  p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (mask == '0));
  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && $past(state) == S_LOAD) |-> $stable(lock_pg));
  p_load_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD) |-> (mask != '0));
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state) == S_LOAD));
endmodule

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;
  localparam int MIN_PW = 3, GAP = 20, PROG = 30;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        busy;
  int total = 0, bad = 0, bcnt = 0;

  page_load_ctrl #(.ADDR_W(13), .DATA_W(8), .OFF_W(6), .MIN_PW(MIN_PW),
    .GAP_CYC(GAP), .PROG_CYC(PROG), .MODEL_PAGES(4)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy));

  always #4 clk = ~clk;
  always @(negedge clk) if (busy) bcnt++;

  localparam logic [20:0] WVEC [7] = '{
    {13'h047, 8'hA1}, {13'h040, 8'h10}, {13'h07F, 8'hE7}, {13'h054, 8'h42},
    {13'h085, 8'h99}, {13'h047, 8'h5B}, {13'h061, 8'h3C}};
  localparam logic [20:0] RVEC [8] = '{
    {13'h047, 8'h5B}, {13'h040, 8'h10}, {13'h07F, 8'hE7}, {13'h054, 8'h42},
    {13'h061, 8'h3C}, {13'h041, 8'hFF}, {13'h07E, 8'hFF}, {13'h085, 8'hFF}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int w, input logic oe);
    @(negedge clk);
    addr = a; din = d; oe_n = oe; ce_n = 0; we_n = 0;
    repeat (w) @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0;
    #2 d = dout;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic busy_timing(input string req);
    repeat (GAP) @(negedge clk);
    chk(req, {7'd0, busy}, 8'd0);
    @(negedge clk);
    chk(req, {7'd0, busy}, 8'd1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, s0, s1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 dout idle", dout, 8'h00);
    rd(13'h045, v); chk("R1 erased", v, 8'hFF);

    for (int i = 0; i < 7; i++) wr(WVEC[i][20:8], WVEC[i][7:0], MIN_PW, 1'b1);
    bcnt = 0;
    busy_timing("R8 timeout");
    rd(13'h100, s0);
    rd(13'h100, s1);
    chk("R10 bit7", {7'd0, s0[7]}, 8'd1);
    chk("R10 low bits", {2'b00, s0[5:0]}, 8'd0);
    chk("R10 toggle", {7'd0, s0[6] ^ s1[6]}, 8'd1);
    wr(13'h0C3, 8'h77, MIN_PW, 1'b1);
    wait_idle();
    chk("R9 busy length", bcnt[7:0], 8'(PROG));
    for (int i = 0; i < 8; i++) begin
      rd(RVEC[i][20:8], v);
      chk("R6 R7 R12 R5 table", v, RVEC[i][7:0]);
    end
    repeat (GAP + 3) @(negedge clk);
    chk("R11 no new load", {7'd0, busy}, 8'd0);
    rd(13'h0C3, v); chk("R11 ignored byte", v, 8'hFF);

    wr(13'h002, 8'h5A, MIN_PW, 1'b0);
    @(negedge clk); addr = 13'h003; din = 8'h66; ce_n = 1; we_n = 0;
    repeat (MIN_PW + 1) @(negedge clk); we_n = 1;
    repeat (GAP + 5) @(negedge clk);
    chk("R2 no load", {7'd0, busy}, 8'd0);
    rd(13'h002, v); chk("R2 oe low", v, 8'hFF);
    rd(13'h003, v); chk("R2 ce high", v, 8'hFF);

    wr(13'h08A, 8'h31, MIN_PW - 1, 1'b1);
    repeat (GAP + 5) @(negedge clk);
    chk("R3 short pulse", {7'd0, busy}, 8'd0);
    wr(13'h08A, 8'h32, MIN_PW, 1'b1);
    busy_timing("R3 min width");
    wait_idle();
    rd(13'h08A, v); chk("R3 accepted", v, 8'h32);
    rd(13'h080, v); chk("R9 mask cleared", v, 8'hFF);

    wr(13'h001, 8'hC1, MIN_PW, 1'b1);
    repeat (GAP - 5) @(negedge clk);
    wr(13'h005, 8'hC5, 10, 1'b1);
    chk("R8 paused", {7'd0, busy}, 8'd0);
    busy_timing("R8 after long strobe");
    wait_idle();
    rd(13'h001, v); chk("R8 first byte", v, 8'hC1);
    rd(13'h005, v); chk("R8 second byte", v, 8'hC5);

    @(negedge clk);
    addr = 13'h0C3; din = 8'h00; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); addr = 13'h0C9; din = 8'hD4;
    repeat (2) @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk); addr = 13'h000;
    repeat (GAP + 2) @(negedge clk);
    wait_idle();
    rd(13'h0C3, v); chk("R4 start address", v, 8'hD4);
    rd(13'h0C9, v); chk("R4 late address", v, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule